// File: doc/BRIEF.md
# Regulator Fault Protection Sequencer

This block is a synchronous supervisor for a switching regulator. It sees the analog side only through one-bit comparator flags. From those flags it decides when the high-side and low-side gate commands may follow the modulator, and when they must be forced. It also drives the reference DAC code and a latched fault status.

There are two overcurrent levels. The fast level sits at 150% of the normal one and latches the block off at once. The normal level latches only after it has stayed asserted for a programmable timeout, which is 50 ms in clock cycles by default.

An overvoltage trip forces the high side off and takes the reference code down one step per programmable interval. While the code falls, the low-side gate follows the output-above-reference comparator. When the code reaches zero, the low side is held on. A supply undervoltage shuts the gates off without latching, and the block restarts once both supplies recover. Latched faults clear only through an enable low-then-high cycle.

Top module: `reg_prot_seq`

## Requirements
- R1: While `en_i` is low, or while `rst_ni` is low, both gate outputs, `rdy_o`, `dac_o` and `fault_o` are zero.
- R2: In normal running, `gh_o` equals `pwm_i`, `gl_o` equals its inverse, and `dac_o` equals `ref_code_i`.
- R3: A fast overcurrent flag seen at a clock edge while running latches fault code 2'b10 at that edge and turns both gates off.
- R4: The normal overcurrent flag latches fault code 2'b01, with both gates off, at the OC_TIMEOUT-th consecutive edge on which it is sampled high. A single low sample restarts the count from zero.
- R5: Any latched fault code persists while `en_i` stays high. A cycle with `en_i` low clears it to 2'b00, and raising `en_i` again returns the block to normal running.
- R6: While `vcc_uv_i` or `vin_uv_i` is high, both gates are off and `rdy_o` is low, and no fault is latched. Once both flags are low, normal running resumes.
- R7: When the overvoltage condition is sampled while running, fault code 2'b11 is latched, `gh_o` goes low and `gl_o` goes high. `dac_o` starts the ramp from the `ref_code_i` value seen at the trip.
- R8: During the ramp, `dac_o` decrements by one every RAMP_STEP cycles, and `gl_o` equals `ov_ref_i`.
- R9: Once `dac_o` reaches zero after an overvoltage trip, `gh_o` stays low and `gl_o` stays high, whatever the comparator flags and `pwm_i` do, until enable is cycled.
- R10: While `ss_i` is high, the overvoltage condition is `ov_fix_i` and `ov_ref_i` is ignored. While `ss_i` is low, the condition is `ov_ref_i` and `ov_fix_i` is ignored.
- R11: Priority at a single edge is: supply undervoltage, then overvoltage, then fast overcurrent, then timed overcurrent.
- R12: `rdy_o` is high only while running with `uv_i`, `ss_i`, both supply flags and `fault_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable; a low cycle clears latched faults |
| vcc_uv_i | input | 1 | Control supply below threshold |
| vin_uv_i | input | 1 | Input supply below threshold |
| oc_i | input | 1 | Normal-level overcurrent flag |
| oc_fast_i | input | 1 | Fast-level (150%) overcurrent flag |
| ov_ref_i | input | 1 | Output above reference plus margin |
| ov_fix_i | input | 1 | Output above fixed soft-start threshold |
| uv_i | input | 1 | Output below target by more than margin |
| ss_i | input | 1 | Soft start in progress |
| pwm_i | input | 1 | Modulator command |
| ref_code_i | input | DAC_W | Reference code requested in normal running |
| gh_o | output | 1 | High-side gate command |
| gl_o | output | 1 | Low-side gate command |
| rdy_o | output | 1 | Output regulated and no fault |
| dac_o | output | DAC_W | Reference DAC code |
| fault_o | output | 2 | Latched fault: 00 none, 01 timed OC, 10 fast OC, 11 OV |

## Verification
The bench holds the normal overcurrent flag for exactly one cycle less than the timeout and checks that nothing latches; a timer off by one would trip early or late. It also inserts a single low sample mid-count, which catches a timer that only pauses instead of restarting. Edges with several faults at once expose a wrong priority order, which would record the wrong fault code or latch through a supply dropout. The ramp is counted step by step to zero, so a wrong step period or a low-side gate that stops tracking the comparator, or that fails to stay on at zero, shows up directly on `dac_o` and `gl_o`.

// File: rtl/reg_prot_pkg.sv
package reg_prot_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_RUN,
    ST_OC_LATCH,
    ST_OV_RAMP,
    ST_OV_HOLD
  } state_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_OC_SLOW = 2'b01,
    FLT_OC_FAST = 2'b10,
    FLT_OV      = 2'b11
  } fault_e;
endpackage

// File: rtl/rps_oc_timer.sv
module rps_oc_timer #(
  parameter int unsigned OC_TIMEOUT = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic oc_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(OC_TIMEOUT + 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && oc_i && (cnt_q == CNT_W'(OC_TIMEOUT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || !oc_i) cnt_q <= '0;
    else if (!expire_o)       cnt_q <= cnt_q + 1'b1;
  end

  AST_TMR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(OC_TIMEOUT)); // R4
  AST_TMR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oc_i |=> cnt_q == '0); // R4
endmodule

// File: rtl/rps_dac_ramp.sv
module rps_dac_ramp #(
  parameter int unsigned DAC_W     = 8,
  parameter int unsigned RAMP_STEP = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DAC_W-1:0] ref_i,
  output logic [DAC_W-1:0] dac_o,
  output logic             zero_o
);
  localparam int unsigned STP_W = $clog2(RAMP_STEP + 1);

  logic [DAC_W-1:0] dac_q;
  logic [STP_W-1:0] stp_q;
  logic             step_hit;

  assign step_hit = stp_q == STP_W'(RAMP_STEP - 1);
  assign zero_o   = dac_q == '0;
  assign dac_o    = dac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q <= '0;
      stp_q <= '0;
    end else if (load_i) begin
      dac_q <= ref_i;
      stp_q <= '0;
    end else if (run_i && !zero_o) begin
      if (step_hit) begin
        dac_q <= dac_q - 1'b1;
        stp_q <= '0;
      end else begin
        stp_q <= stp_q + 1'b1;
      end
    end
  end

  AST_RAMP_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> (dac_q == $past(dac_q) || dac_q == $past(dac_q) - 1'b1)); // R8
endmodule

// File: rtl/reg_prot_seq.sv
module reg_prot_seq
  import reg_prot_pkg::*;
#(
  parameter int unsigned DAC_W      = 8,
  parameter int unsigned OC_TIMEOUT = 5_000_000,
  parameter int unsigned RAMP_STEP  = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             vcc_uv_i,
  input  logic             vin_uv_i,
  input  logic             oc_i,
  input  logic             oc_fast_i,
  input  logic             ov_ref_i,
  input  logic             ov_fix_i,
  input  logic             uv_i,
  input  logic             ss_i,
  input  logic             pwm_i,
  input  logic [DAC_W-1:0] ref_code_i,
  output logic             gh_o,
  output logic             gl_o,
  output logic             rdy_o,
  output logic [DAC_W-1:0] dac_o,
  output logic [1:0]       fault_o
);
  state_e state_q, state_d;
  fault_e fault_q, fault_d;

  logic             sup_uv, ov_trip, oc_expire;
  logic             ramp_load, ramp_run, ramp_zero;
  logic [DAC_W-1:0] ramp_code;

  assign sup_uv  = vcc_uv_i || vin_uv_i;
  assign ov_trip = ss_i ? ov_fix_i : ov_ref_i;

  rps_oc_timer #(.OC_TIMEOUT(OC_TIMEOUT)) u_oc_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q == ST_RUN),
    .oc_i    (oc_i),
    .expire_o(oc_expire)
  );

  assign ramp_load = (state_d == ST_OV_RAMP) && (state_q == ST_RUN);
  assign ramp_run  = state_q == ST_OV_RAMP;

  rps_dac_ramp #(.DAC_W(DAC_W), .RAMP_STEP(RAMP_STEP)) u_dac_ramp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ramp_load),
    .run_i (ramp_run),
    .ref_i (ref_code_i),
    .dac_o (ramp_code),
    .zero_o(ramp_zero)
  );

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    if (!en_i) begin
      state_d = ST_OFF;
      fault_d = FLT_NONE;
    end else begin
      unique case (state_q)
        ST_OFF: if (!sup_uv) state_d = ST_RUN;
        ST_RUN: begin
          if (sup_uv) begin
            state_d = ST_OFF;
          end else if (ov_trip) begin
            state_d = ST_OV_RAMP;
            fault_d = FLT_OV;
          end else if (oc_fast_i) begin
            state_d = ST_OC_LATCH;
            fault_d = FLT_OC_FAST;
          end else if (oc_expire) begin
            state_d = ST_OC_LATCH;
            fault_d = FLT_OC_SLOW;
          end
        end
        ST_OV_RAMP: if (ramp_zero) state_d = ST_OV_HOLD;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      fault_q <= FLT_NONE;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
    end
  end

  always_comb begin
    gh_o = 1'b0;
    gl_o = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        gh_o = pwm_i;
        gl_o = !pwm_i;
      end
      ST_OV_RAMP: gl_o = ov_ref_i || ramp_zero;
      ST_OV_HOLD: gl_o = 1'b1;
      default: ;
    endcase
    if (sup_uv) begin
      gh_o = 1'b0;
      gl_o = 1'b0;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_RUN:                dac_o = ref_code_i;
      ST_OV_RAMP, ST_OV_HOLD: dac_o = ramp_code;
      default:               dac_o = '0;
    endcase
  end

  assign rdy_o   = (state_q == ST_RUN) && !sup_uv && !ss_i && !uv_i;
  assign fault_o = fault_q;

  AST_FLT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fault_q != FLT_NONE) |=> fault_q == $past(fault_q)); // R5
  AST_UV_GATES_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_uv |-> (!gh_o && !gl_o && !rdy_o)); // R6
  AST_OV_NO_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OV_RAMP || state_q == ST_OV_HOLD) |-> !gh_o); // R7
  AST_HOLD_LS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OV_HOLD && !sup_uv) |-> (gl_o && dac_o == '0)); // R9
  AST_FAST_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && en_i && !sup_uv && !ov_trip && oc_fast_i)
      |=> fault_q == FLT_OC_FAST); // R3
  AST_FLT_NO_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q != FLT_NONE) |-> !rdy_o); // R12
endmodule

// File: tb/reg_prot_seq_tb_top.sv
module reg_prot_seq_tb_top;
  localparam int unsigned DAC_W = 8;
  localparam int unsigned TMO   = 20;
  localparam int unsigned STEP  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en, vcc_uv, vin_uv, oc, oc_fast, ov_ref, ov_fix, uv, ss, pwm;
  logic [DAC_W-1:0] ref_code;
  logic gh, gl, rdy;
  logic [DAC_W-1:0] dac;
  logic [1:0] fault;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  reg_prot_seq #(.DAC_W(DAC_W), .OC_TIMEOUT(TMO), .RAMP_STEP(STEP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .vcc_uv_i(vcc_uv), .vin_uv_i(vin_uv),
    .oc_i(oc), .oc_fast_i(oc_fast), .ov_ref_i(ov_ref), .ov_fix_i(ov_fix),
    .uv_i(uv), .ss_i(ss), .pwm_i(pwm), .ref_code_i(ref_code),
    .gh_o(gh), .gl_o(gl), .rdy_o(rdy), .dac_o(dac), .fault_o(fault)
  );

  typedef struct packed {
    logic pwm, ss, uv, ovr, ovf;
    logic [7:0] rc;
    logic gh, gl, rdy;
    logic [7:0] dac;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h40, 1'b1, 1'b0, 1'b1, 8'h40},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h41, 1'b0, 1'b1, 1'b1, 8'h41},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h42, 1'b1, 1'b0, 1'b0, 8'h42},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h43, 1'b1, 1'b0, 1'b0, 8'h43},
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h44, 1'b0, 1'b1, 1'b0, 8'h44},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 1'b1, 1'b0, 1'b1, 8'h80}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    vcc_uv = 0; vin_uv = 0; oc = 0; oc_fast = 0;
    ov_ref = 0; ov_fix = 0; uv = 0; ss = 0;
  endtask

  task automatic go_run();
    clear_flags();
    en = 0; tick();
    en = 1; tick();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    clear_flags();
    en = 1; pwm = 1; ref_code = 8'h30;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 rst gates", {gh, gl, rdy}, 0);
    chk("R1 rst dac/fault", {dac, fault}, 0);
    rst_n = 1;
    tick();
    chk("R2 run gh", gh, 1);
    chk("R12 run rdy", rdy, 1);

    // R2 R10 R12 vector table, no trip expected
    for (int i = 0; i < 6; i++) begin
      pwm = VEC[i].pwm; ss = VEC[i].ss; uv = VEC[i].uv;
      ov_ref = VEC[i].ovr; ov_fix = VEC[i].ovf; ref_code = VEC[i].rc;
      tick();
      chk("R2 vec gh", gh, VEC[i].gh);
      chk("R2 vec gl", gl, VEC[i].gl);
      chk("R12 vec rdy", rdy, VEC[i].rdy);
      chk("R2 vec dac", dac, VEC[i].dac);
      chk("R10 vec no fault", fault, 0);
    end
    clear_flags();

    // R1 enable low
    en = 0; tick();
    chk("R1 en low outs", {gh, gl, rdy, dac, fault}, 0);
    en = 1; tick();

    // R4 timed overcurrent
    pwm = 1; oc = 1;
    repeat (TMO - 1) tick();
    chk("R4 before timeout fault", fault, 0);
    chk("R4 before timeout gh", gh, 1);
    tick();
    chk("R4 timeout fault", fault, 2'b01);
    chk("R4 timeout gates", {gh, gl}, 0);
    // R5 latch holds
    oc = 0;
    repeat (5) tick();
    chk("R5 latch held", fault, 2'b01);
    chk("R5 no rdy", rdy, 0);
    en = 0; tick();
    chk("R5 cleared", fault, 0);
    en = 1; tick();
    chk("R5 rerun rdy", rdy, 1);

    // R4 timer restarts on a single low sample
    oc = 1; repeat (10) tick();
    oc = 0; tick();
    oc = 1; repeat (TMO - 1) tick();
    chk("R4 restart no fault", fault, 0);
    tick();
    chk("R4 restart fault", fault, 2'b01);
    go_run();

    // R3 fast overcurrent
    pwm = 0; oc_fast = 1; tick();
    chk("R3 fast fault", fault, 2'b10);
    chk("R3 fast gates", {gh, gl}, 0);
    go_run();

    // R11 OV beats fast OC
    ov_ref = 1; oc_fast = 1; tick();
    chk("R11 ov over fast", fault, 2'b11);
    go_run();

    // R11 fast beats timed
    oc = 1; repeat (TMO - 1) tick();
    oc_fast = 1; tick();
    chk("R11 fast over timed", fault, 2'b10);
    go_run();

    // R6 R11 supply UV beats OV
    pwm = 1; vin_uv = 1; ov_ref = 1; #1;
    chk("R6 uv gates comb", {gh, gl, rdy}, 0);
    tick();
    chk("R11 uv no fault", fault, 0);
    chk("R6 uv gates", {gh, gl, rdy}, 0);
    vin_uv = 0; ov_ref = 0; vcc_uv = 1; tick();
    chk("R6 vcc uv gates", {gh, gl}, 0);
    vcc_uv = 0; pwm = 0; tick();
    chk("R6 recover gl", gl, 1);
    chk("R6 recover rdy", rdy, 1);

    // R10 soft-start fixed threshold
    ss = 1; ov_fix = 1; tick();
    chk("R10 ss fixed trip", fault, 2'b11);
    go_run();

    // R7 R8 R9 overvoltage ramp
    ref_code = 8'd5; pwm = 1; ov_ref = 1; tick();
    chk("R7 ov fault", fault, 2'b11);
    chk("R7 ov gates", {gh, gl}, 2'b01);
    chk("R7 ov dac", dac, 5);
    ref_code = 8'd99;
    repeat (STEP - 1) tick();
    chk("R8 dac before step", dac, 5);
    tick();
    chk("R8 dac after step", dac, 4);
    ov_ref = 0; #1;
    chk("R8 gl tracks low", gl, 0);
    ov_ref = 1; #1;
    chk("R8 gl tracks high", gl, 1);
    ov_ref = 0;
    repeat (4 * STEP - 1) tick();
    chk("R8 dac one", dac, 1);
    tick();
    chk("R9 dac zero", dac, 0);
    chk("R9 gl at zero", {gh, gl}, 2'b01);
    oc_fast = 1; pwm = 0;
    repeat (3) tick();
    chk("R9 hold gates", {gh, gl}, 2'b01);
    chk("R9 hold fault", fault, 2'b11);
    go_run();
    chk("R5 ov cleared", fault, 0);
    chk("R5 ov rerun dac", dac, 99);

    report();
  end
endmodule